// File: doc/BRIEF.md
# DDR4 Power-Up Initialization Sequencer

This block brings a DDR4 memory device from power-up to an idle, usable state without any help from software. Once its own reset is released, it lets go of the memory reset line and waits. It then raises clock enable and waits again. Next it writes the seven mode registers, each in a single command cycle. A long ZQ calibration follows, and after a final settling interval the block raises a done flag. The four waits are compile-time parameters.

The mode register contents are not stored anywhere. Each one is packed from configuration inputs given as plain values: burst length selection, CAS latency, write recovery, CAS write latency, tCCD, drive strength, and the two termination codes. The CAS latency and write recovery codes are split across non-contiguous MR0 fields. The configuration must be held stable for the whole sequence. The block checks whether the latency, recovery and tCCD values have a legal encoding. If any of them does not, the sequencer stops at the point where the first mode register write would go out, raises an error flag, and issues no command at all.

Top module: `dram_powerup_seq`

## Requirements
- R1: While `rstN` is low, the outputs are in their reset state: `memResetN`=0, `memCke`=0, the command lines at NOP ({`memCsN`,`memRasN`,`memCasN`,`memWeN`} = 4'b1111), `initDone`=0 and `cfgError`=0. This also applies when reset is applied in the middle of a sequence.
- R2: `memResetN` rises one cycle after `rstN` is released. `memCke` rises exactly RESET_WAIT cycles after `memResetN` rises. `memCke` is never high while `memResetN` is low.
- R3: The first mode register write appears exactly CKE_WAIT cycles after `memCke` rises. No command is issued while `memCke` is low, and `memCke` stays high until the next reset.
- R4: Seven mode register writes go out on consecutive cycles, each encoded as 4'b0000 on the command lines. `memBank` carries the register index in the order 3, 6, 5, 4, 2, 1, 0.
- R5: MR0 is packed as follows. Bits 1:0 hold 00 for BL8 or 10 for BL4 (`cfgBurstChop`=1). Bit 8 is set (DLL reset). The CAS latency code c goes to bit 2 (c[0]), bits 6:4 (c[3:1]) and bit 12 (c[4]). The recovery code w goes to bits 11:9 (w[2:0]) and bit 13 (w[3]). The latency codes are: CL9..16 give 0..7; CL18, 20, 22, 24 give 8..11; CL23, 17, 19, 21 give 12..15; CL25..32 give 16..23. The recovery codes are: WR10, 12, 14, 16, 18, 20 give 0..5; WR24 gives 6; WR22 gives 7; WR26 gives 8; WR28 gives 9.
- R6: MR1 carries the drive code in bits 2:1 (01 when `cfgDrive48`=1, else 00) and `cfgRttNom` in bits 10:8. All other bits are zero.
- R7: MR2 carries the CWL code in bits 5:3 and `cfgRttWr` in bits 11:9. The CWL codes are: CWL9, 10, 11, 12 give 0..3; CWL14, 16, 18, 20 give 4..7.
- R8: MR6 carries the tCCD code (tCCD 4..8 give 0..4) in bits 12:10. MR3, MR4 and MR5 are written as all zeros.
- R9: Exactly MR0_WAIT cycles after the MR0 write, one ZQ calibration command is issued. It is encoded as {`memCsN`,`memRasN`,`memCasN`,`memWeN`} = 4'b0110, with `memAddr`=14'h0400 and `memBank`=0.
- R10: `initDone` rises exactly ZQ_WAIT cycles after the ZQ command and stays high until reset.
- R11: If CL, WR, CWL or tCCD has no legal code, `cfgError` rises in the cycle the first mode register write would have appeared. No command is ever issued, and `initDone` stays low.
- R12: Every command lasts one cycle. Whenever `memCsN` is high, `memRasN`, `memCasN` and `memWeN` are high as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgBurstChop | input | 1 | 1 selects BL4, 0 selects BL8 |
| cfgCasLat | input | 6 | CAS latency in cycles |
| cfgWrRecov | input | 5 | Write recovery in cycles |
| cfgCasWrLat | input | 5 | CAS write latency in cycles |
| cfgCcd | input | 4 | CAS-to-CAS delay in cycles |
| cfgDrive48 | input | 1 | 1 selects 48 ohm drive, 0 selects 34 ohm |
| cfgRttNom | input | 3 | Nominal termination code |
| cfgRttWr | input | 3 | Write termination code |
| memResetN | output | 1 | Memory reset, active low |
| memCke | output | 1 | Clock enable |
| memCsN | output | 1 | Chip select, active low |
| memRasN | output | 1 | Row strobe, active low |
| memCasN | output | 1 | Column strobe, active low |
| memWeN | output | 1 | Write enable, active low |
| memBank | output | 3 | Bank address (mode register index) |
| memAddr | output | 14 | Address bus |
| initDone | output | 1 | Sequence complete |
| cfgError | output | 1 | Unsupported configuration detected |

## Verification
The bench builds the block with RESET_WAIT=12, CKE_WAIT=7, MR0_WAIT=5 and ZQ_WAIT=4. With these values a whole sequence fits in about forty cycles, so every interval can be measured exactly in each of several scenarios. Because the four values are distinct, a wait counter loaded with the wrong stage's value produces a wrong interval. The short run also leaves room for corner configurations: the highest CL and WR codes that use MR0 bits 12 and 13, the out-of-order codes CL17 and WR22, each illegal field on its own, and a reset in mid-sequence.

// File: rtl/dram_powerup_pkg.sv
package dram_powerup_pkg;

  localparam int ADDR_W = 14;
  localparam int BANK_W = 3;
  localparam int NUM_MR = 7;
  localparam logic [ADDR_W-1:0] ZQ_ADDR = 14'h0400;

  typedef struct packed {
    logic csN;
    logic rasN;
    logic casN;
    logic weN;
  } cmdLines_t;

  localparam cmdLines_t CMD_NOP = 4'b1111;
  localparam cmdLines_t CMD_MRS = 4'b0000;
  localparam cmdLines_t CMD_ZQ  = 4'b0110;

  // strobes from the sequencer control to the datapath
  typedef struct packed {
    logic              relReset;
    logic              raiseCke;
    logic              issueMrs;
    logic [BANK_W-1:0] mrIdx;
    logic              issueZq;
    logic              setDone;
    logic              setErr;
  } seqStrobe_t;

  // write position -> mode register index (DDR4 load order)
  function automatic logic [BANK_W-1:0] mrOrder(input logic [2:0] pos);
    case (pos)
      3'd0:    return 3'd3;
      3'd1:    return 3'd6;
      3'd2:    return 3'd5;
      3'd3:    return 3'd4;
      3'd4:    return 3'd2;
      3'd5:    return 3'd1;
      default: return 3'd0;
    endcase
  endfunction

  // {valid, code[4:0]}
  function automatic logic [5:0] clCode(input logic [5:0] cl);
    if (cl >= 6'd9 && cl <= 6'd16)  return {1'b1, 5'(cl - 6'd9)};
    if (cl >= 6'd25 && cl <= 6'd32) return {1'b1, 5'(cl - 6'd9)};
    case (cl)
      6'd18:   return {1'b1, 5'd8};
      6'd20:   return {1'b1, 5'd9};
      6'd22:   return {1'b1, 5'd10};
      6'd24:   return {1'b1, 5'd11};
      6'd23:   return {1'b1, 5'd12};
      6'd17:   return {1'b1, 5'd13};
      6'd19:   return {1'b1, 5'd14};
      6'd21:   return {1'b1, 5'd15};
      default: return 6'd0;
    endcase
  endfunction

  // {valid, code[3:0]}
  function automatic logic [4:0] wrCode(input logic [4:0] wr);
    case (wr)
      5'd10:   return {1'b1, 4'd0};
      5'd12:   return {1'b1, 4'd1};
      5'd14:   return {1'b1, 4'd2};
      5'd16:   return {1'b1, 4'd3};
      5'd18:   return {1'b1, 4'd4};
      5'd20:   return {1'b1, 4'd5};
      5'd24:   return {1'b1, 4'd6};
      5'd22:   return {1'b1, 4'd7};
      5'd26:   return {1'b1, 4'd8};
      5'd28:   return {1'b1, 4'd9};
      default: return 5'd0;
    endcase
  endfunction

  // {valid, code[2:0]}
  function automatic logic [3:0] cwlCode(input logic [4:0] cwl);
    case (cwl)
      5'd9:    return {1'b1, 3'd0};
      5'd10:   return {1'b1, 3'd1};
      5'd11:   return {1'b1, 3'd2};
      5'd12:   return {1'b1, 3'd3};
      5'd14:   return {1'b1, 3'd4};
      5'd16:   return {1'b1, 3'd5};
      5'd18:   return {1'b1, 3'd6};
      5'd20:   return {1'b1, 3'd7};
      default: return 4'd0;
    endcase
  endfunction

  // {valid, code[2:0]}
  function automatic logic [3:0] ccdCode(input logic [3:0] ccd);
    if (ccd >= 4'd4 && ccd <= 4'd8) return {1'b1, 3'(ccd - 4'd4)};
    return 4'd0;
  endfunction

endpackage

// File: rtl/dram_powerup_ctrl.sv
module dram_powerup_ctrl
  import dram_powerup_pkg::*;
#(
  parameter int RESET_WAIT = 50000,
  parameter int CKE_WAIT   = 10000,
  parameter int MR0_WAIT   = 200,
  parameter int ZQ_WAIT    = 200
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgBad,
  output seqStrobe_t strobe
);

  localparam int MAX_A    = (RESET_WAIT > CKE_WAIT) ? RESET_WAIT : CKE_WAIT;
  localparam int MAX_B    = (MR0_WAIT > ZQ_WAIT) ? MR0_WAIT : ZQ_WAIT;
  localparam int MAX_WAIT = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);

  typedef enum logic [2:0] {
    ST_START, ST_WRST, ST_WCKE, ST_MRS, ST_WMR0, ST_WZQ, ST_DONE, ST_HALT
  } seqState_t;

  seqState_t         state, stateNxt;
  logic [CNT_W-1:0]  cnt, cntNxt;
  logic [2:0]        pos, posNxt;
  logic              cntZero;

  assign cntZero = (cnt == '0);

  always_comb begin
    stateNxt = state;
    cntNxt   = cntZero ? cnt : cnt - 1'b1;
    posNxt   = pos;
    strobe   = '0;
    case (state)
      ST_START: begin
        strobe.relReset = 1'b1;
        stateNxt        = ST_WRST;
        cntNxt          = CNT_W'(RESET_WAIT - 1);
      end
      ST_WRST: if (cntZero) begin
        strobe.raiseCke = 1'b1;
        stateNxt        = ST_WCKE;
        cntNxt          = CNT_W'(CKE_WAIT - 1);
      end
      ST_WCKE: if (cntZero) begin
        if (cfgBad) begin
          strobe.setErr = 1'b1;
          stateNxt      = ST_HALT;
        end else begin
          strobe.issueMrs = 1'b1;
          strobe.mrIdx    = mrOrder(3'd0);
          posNxt          = 3'd1;
          stateNxt        = ST_MRS;
        end
      end
      ST_MRS: begin
        strobe.issueMrs = 1'b1;
        strobe.mrIdx    = mrOrder(pos);
        if (pos == 3'(NUM_MR - 1)) begin
          stateNxt = ST_WMR0;
          cntNxt   = CNT_W'(MR0_WAIT - 1);
        end else begin
          posNxt = pos + 3'd1;
        end
      end
      ST_WMR0: if (cntZero) begin
        strobe.issueZq = 1'b1;
        stateNxt       = ST_WZQ;
        cntNxt         = CNT_W'(ZQ_WAIT - 1);
      end
      ST_WZQ: if (cntZero) begin
        strobe.setDone = 1'b1;
        stateNxt       = ST_DONE;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_START;
      cnt   <= '0;
      pos   <= '0;
    end else begin
      state <= stateNxt;
      cnt   <= cntNxt;
      pos   <= posNxt;
    end
  end

endmodule

// File: rtl/dram_powerup_dp.sv
module dram_powerup_dp
  import dram_powerup_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic              cfgBurstChop,
  input  logic [5:0]        cfgCasLat,
  input  logic [4:0]        cfgWrRecov,
  input  logic [4:0]        cfgCasWrLat,
  input  logic [3:0]        cfgCcd,
  input  logic              cfgDrive48,
  input  logic [2:0]        cfgRttNom,
  input  logic [2:0]        cfgRttWr,
  output logic              cfgBad,
  output logic              memResetN,
  output logic              memCke,
  output cmdLines_t         memCmd,
  output logic [BANK_W-1:0] memBank,
  output logic [ADDR_W-1:0] memAddr,
  output logic              initDone,
  output logic              cfgError
);

  logic [5:0]        clR;
  logic [4:0]        wrR;
  logic [3:0]        cwlR, ccdR;
  logic [ADDR_W-1:0] mr0, mr1, mr2, mr6, mrWord;

  always_comb begin
    clR  = clCode(cfgCasLat);
    wrR  = wrCode(cfgWrRecov);
    cwlR = cwlCode(cfgCasWrLat);
    ccdR = ccdCode(cfgCcd);
    cfgBad = !(clR[5] && wrR[4] && cwlR[3] && ccdR[3]);

    mr0        = '0;
    mr0[1:0]   = cfgBurstChop ? 2'b10 : 2'b00;
    mr0[2]     = clR[0];
    mr0[6:4]   = clR[3:1];
    mr0[12]    = clR[4];
    mr0[8]     = 1'b1;
    mr0[11:9]  = wrR[2:0];
    mr0[13]    = wrR[3];

    mr1        = '0;
    mr1[2:1]   = {1'b0, cfgDrive48};
    mr1[10:8]  = cfgRttNom;

    mr2        = '0;
    mr2[5:3]   = cwlR[2:0];
    mr2[11:9]  = cfgRttWr;

    mr6        = '0;
    mr6[12:10] = ccdR[2:0];

    case (strobe.mrIdx)
      3'd0:    mrWord = mr0;
      3'd1:    mrWord = mr1;
      3'd2:    mrWord = mr2;
      3'd6:    mrWord = mr6;
      default: mrWord = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memResetN <= 1'b0;
      memCke    <= 1'b0;
      memCmd    <= CMD_NOP;
      memBank   <= '0;
      memAddr   <= '0;
      initDone  <= 1'b0;
      cfgError  <= 1'b0;
    end else begin
      if (strobe.relReset) memResetN <= 1'b1;
      if (strobe.raiseCke) memCke    <= 1'b1;
      if (strobe.setDone)  initDone  <= 1'b1;
      if (strobe.setErr)   cfgError  <= 1'b1;
      if (strobe.issueMrs) begin
        memCmd  <= CMD_MRS;
        memBank <= strobe.mrIdx;
        memAddr <= mrWord;
      end else if (strobe.issueZq) begin
        memCmd  <= CMD_ZQ;
        memBank <= '0;
        memAddr <= ZQ_ADDR;
      end else begin
        memCmd  <= CMD_NOP;
        memBank <= '0;
        memAddr <= '0;
      end
    end
  end

endmodule

// File: rtl/dram_powerup_seq.sv
module dram_powerup_seq
  import dram_powerup_pkg::*;
#(
  parameter int RESET_WAIT = 50000,
  parameter int CKE_WAIT   = 10000,
  parameter int MR0_WAIT   = 200,
  parameter int ZQ_WAIT    = 200
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgBurstChop,
  input  logic [5:0]  cfgCasLat,
  input  logic [4:0]  cfgWrRecov,
  input  logic [4:0]  cfgCasWrLat,
  input  logic [3:0]  cfgCcd,
  input  logic        cfgDrive48,
  input  logic [2:0]  cfgRttNom,
  input  logic [2:0]  cfgRttWr,
  output logic        memResetN,
  output logic        memCke,
  output logic        memCsN,
  output logic        memRasN,
  output logic        memCasN,
  output logic        memWeN,
  output logic [2:0]  memBank,
  output logic [13:0] memAddr,
  output logic        initDone,
  output logic        cfgError
);

  seqStrobe_t strobe;
  cmdLines_t  memCmd;
  logic       cfgBad;

  dram_powerup_ctrl #(
    .RESET_WAIT(RESET_WAIT),
    .CKE_WAIT  (CKE_WAIT),
    .MR0_WAIT  (MR0_WAIT),
    .ZQ_WAIT   (ZQ_WAIT)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .cfgBad(cfgBad),
    .strobe(strobe)
  );

  dram_powerup_dp u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .cfgBurstChop(cfgBurstChop),
    .cfgCasLat   (cfgCasLat),
    .cfgWrRecov  (cfgWrRecov),
    .cfgCasWrLat (cfgCasWrLat),
    .cfgCcd      (cfgCcd),
    .cfgDrive48  (cfgDrive48),
    .cfgRttNom   (cfgRttNom),
    .cfgRttWr    (cfgRttWr),
    .cfgBad      (cfgBad),
    .memResetN   (memResetN),
    .memCke      (memCke),
    .memCmd      (memCmd),
    .memBank     (memBank),
    .memAddr     (memAddr),
    .initDone    (initDone),
    .cfgError    (cfgError)
  );

  assign memCsN  = memCmd.csN;
  assign memRasN = memCmd.rasN;
  assign memCasN = memCmd.casN;
  assign memWeN  = memCmd.weN;

endmodule

// File: rtl/dram_powerup_chk.sv
module dram_powerup_chk (
  input logic        clk,
  input logic        rstN,
  input logic        memResetN,
  input logic        memCke,
  input logic        memCsN,
  input logic        memRasN,
  input logic        memCasN,
  input logic        memWeN,
  input logic [2:0]  memBank,
  input logic [13:0] memAddr,
  input logic        initDone,
  input logic        cfgError
);

  logic isMrs, isZq, zqSeen;
  assign isMrs = ({memCsN, memRasN, memCasN, memWeN} == 4'b0000);
  assign isZq  = ({memCsN, memRasN, memCasN, memWeN} == 4'b0110);

  function automatic logic [2:0] nextMr(input logic [2:0] idx);
    case (idx)
      3'd3:    return 3'd6;
      3'd6:    return 3'd5;
      3'd5:    return 3'd4;
      3'd4:    return 3'd2;
      3'd2:    return 3'd1;
      default: return 3'd0;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     zqSeen <= 1'b0;
    else if (isZq) zqSeen <= 1'b1;
  end

  p_cke_after_rst_r2: assert property (@(posedge clk) disable iff (!rstN)
    memCke |-> memResetN);

  p_cmd_needs_cke_r3: assert property (@(posedge clk) disable iff (!rstN)
    !memCsN |-> memCke);

  p_cke_stays_r3: assert property (@(posedge clk) disable iff (!rstN)
    memCke |=> memCke);

  p_mr_order_r4: assert property (@(posedge clk) disable iff (!rstN)
    (isMrs && $past(isMrs)) |-> (memBank == nextMr($past(memBank))));

  p_dll_reset_r5: assert property (@(posedge clk) disable iff (!rstN)
    (isMrs && memBank == 3'd0) |-> memAddr[8]);

  p_zero_regs_r8: assert property (@(posedge clk) disable iff (!rstN)
    (isMrs && (memBank == 3'd3 || memBank == 3'd4 || memBank == 3'd5)) |-> (memAddr == '0));

  p_zq_addr_r9: assert property (@(posedge clk) disable iff (!rstN)
    isZq |-> (memAddr == 14'h0400 && memBank == 3'd0));

  p_done_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone);

  p_done_after_zq_r10: assert property (@(posedge clk) disable iff (!rstN)
    initDone |-> zqSeen);

  p_err_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |-> (memCsN && !initDone));

  p_nop_idle_r12: assert property (@(posedge clk) disable iff (!rstN)
    memCsN |-> (memRasN && memCasN && memWeN));

  p_cmd_legal_r12: assert property (@(posedge clk) disable iff (!rstN)
    !memCsN |-> (isMrs || isZq));

endmodule

bind dram_powerup_seq dram_powerup_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .memResetN(memResetN),
  .memCke   (memCke),
  .memCsN   (memCsN),
  .memRasN  (memRasN),
  .memCasN  (memCasN),
  .memWeN   (memWeN),
  .memBank  (memBank),
  .memAddr  (memAddr),
  .initDone (initDone),
  .cfgError (cfgError)
);

// File: tb/tb_dram_powerup_seq.sv
`timescale 1ns/1ps
module tb_dram_powerup_seq;

  localparam int RW  = 12;
  localparam int CW  = 7;
  localparam int M0W = 5;
  localparam int ZW  = 4;
  localparam int RUN = 60;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgBurstChop = 1'b0;
  logic [5:0]  cfgCasLat = 6'd9;
  logic [4:0]  cfgWrRecov = 5'd10;
  logic [4:0]  cfgCasWrLat = 5'd9;
  logic [3:0]  cfgCcd = 4'd4;
  logic        cfgDrive48 = 1'b0;
  logic [2:0]  cfgRttNom = 3'd3;
  logic [2:0]  cfgRttWr = 3'd1;
  logic        memResetN, memCke, memCsN, memRasN, memCasN, memWeN;
  logic [2:0]  memBank;
  logic [13:0] memAddr;
  logic        initDone, cfgError;

  always #2.5 clk = ~clk;

  dram_powerup_seq #(
    .RESET_WAIT(RW), .CKE_WAIT(CW), .MR0_WAIT(M0W), .ZQ_WAIT(ZW)
  ) dut (
    .clk(clk), .rstN(rstN),
    .cfgBurstChop(cfgBurstChop), .cfgCasLat(cfgCasLat), .cfgWrRecov(cfgWrRecov),
    .cfgCasWrLat(cfgCasWrLat), .cfgCcd(cfgCcd), .cfgDrive48(cfgDrive48),
    .cfgRttNom(cfgRttNom), .cfgRttWr(cfgRttWr),
    .memResetN(memResetN), .memCke(memCke), .memCsN(memCsN), .memRasN(memRasN),
    .memCasN(memCasN), .memWeN(memWeN), .memBank(memBank), .memAddr(memAddr),
    .initDone(initDone), .cfgError(cfgError)
  );

  int checks = 0;
  int failures = 0;

  // recorded trace of one run
  int         resetRise, ckeRise, doneRise, errRise;
  int         ckeDrop, doneDrop, nopBad, nCmd;
  int         cmdCyc[16];
  logic [3:0] cmdCode[16];
  logic [2:0] cmdBank[16];
  logic [13:0] cmdAddr[16];
  int         expOrder[7] = '{3, 6, 5, 4, 2, 1, 0};

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic setCfg(input logic bc, input int cl, input int wr, input int cwl,
                        input int ccd, input logic d48, input int rn, input int rwr);
    cfgBurstChop = bc;
    cfgCasLat    = 6'(cl);
    cfgWrRecov   = 5'(wr);
    cfgCasWrLat  = 5'(cwl);
    cfgCcd       = 4'(ccd);
    cfgDrive48   = d48;
    cfgRttNom    = 3'(rn);
    cfgRttWr     = 3'(rwr);
  endtask

  task automatic checkResetState(input string what);
    check(memResetN == 1'b0, "R1", {what, " memResetN"}, int'(memResetN), 0);
    check(memCke == 1'b0, "R1", {what, " memCke"}, int'(memCke), 0);
    check({memCsN, memRasN, memCasN, memWeN} == 4'b1111, "R1", {what, " cmd"},
          int'({memCsN, memRasN, memCasN, memWeN}), 15);
    check(initDone == 1'b0, "R1", {what, " initDone"}, int'(initDone), 0);
    check(cfgError == 1'b0, "R1", {what, " cfgError"}, int'(cfgError), 0);
  endtask

  task automatic runSeq();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    checkResetState("held");
    resetRise = -1; ckeRise = -1; doneRise = -1; errRise = -1;
    ckeDrop = 0; doneDrop = 0; nopBad = 0; nCmd = 0;
    rstN = 1'b1;
    for (int n = 1; n <= RUN; n++) begin
      @(negedge clk);
      if (memResetN && resetRise < 0) resetRise = n;
      if (memCke && ckeRise < 0) ckeRise = n;
      if (initDone && doneRise < 0) doneRise = n;
      if (cfgError && errRise < 0) errRise = n;
      if (ckeRise >= 0 && !memCke) ckeDrop++;
      if (doneRise >= 0 && !initDone) doneDrop++;
      if (memCsN && {memRasN, memCasN, memWeN} != 3'b111) nopBad++;
      if (!memCsN && nCmd < 16) begin
        cmdCyc[nCmd]  = n;
        cmdCode[nCmd] = {memCsN, memRasN, memCasN, memWeN};
        cmdBank[nCmd] = memBank;
        cmdAddr[nCmd] = memAddr;
        nCmd++;
      end
    end
  endtask

  task automatic checkNormal(input string tag, input int mr0, input int mr1,
                             input int mr2, input int mr6);
    int expWord;
    check(resetRise == 1, "R2", {tag, " memResetN rise cycle"}, resetRise, 1);
    check(ckeRise - resetRise == RW, "R2", {tag, " reset->cke"}, ckeRise - resetRise, RW);
    check(ckeDrop == 0, "R3", {tag, " cke held"}, ckeDrop, 0);
    check(nCmd == 8, "R4", {tag, " command count"}, nCmd, 8);
    if (nCmd == 8) begin
      check(cmdCyc[0] - ckeRise == CW, "R3", {tag, " cke->first MRS"}, cmdCyc[0] - ckeRise, CW);
      for (int i = 0; i < 7; i++) begin
        check(cmdCode[i] == 4'b0000, "R4", {tag, " MRS encoding"}, int'(cmdCode[i]), 0);
        check(int'(cmdBank[i]) == expOrder[i], "R4", {tag, " MR order"}, int'(cmdBank[i]), expOrder[i]);
        if (i > 0)
          check(cmdCyc[i] - cmdCyc[i-1] == 1, "R4", {tag, " MRS back to back"},
                cmdCyc[i] - cmdCyc[i-1], 1);
        case (expOrder[i])
          0: expWord = mr0;
          1: expWord = mr1;
          2: expWord = mr2;
          6: expWord = mr6;
          default: expWord = 0;
        endcase
        case (expOrder[i])
          0: check(int'(cmdAddr[i]) == expWord, "R5", {tag, " MR0 word"}, int'(cmdAddr[i]), expWord);
          1: check(int'(cmdAddr[i]) == expWord, "R6", {tag, " MR1 word"}, int'(cmdAddr[i]), expWord);
          2: check(int'(cmdAddr[i]) == expWord, "R7", {tag, " MR2 word"}, int'(cmdAddr[i]), expWord);
          default: check(int'(cmdAddr[i]) == expWord, "R8", {tag, " MR3/4/5/6 word"}, int'(cmdAddr[i]), expWord);
        endcase
      end
      check(cmdCode[7] == 4'b0110, "R9", {tag, " ZQ encoding"}, int'(cmdCode[7]), 6);
      check(cmdAddr[7] == 14'h0400, "R9", {tag, " ZQ address"}, int'(cmdAddr[7]), 'h400);
      check(cmdBank[7] == 3'd0, "R9", {tag, " ZQ bank"}, int'(cmdBank[7]), 0);
      check(cmdCyc[7] - cmdCyc[6] == M0W, "R9", {tag, " MR0->ZQ"}, cmdCyc[7] - cmdCyc[6], M0W);
      check(doneRise - cmdCyc[7] == ZW, "R10", {tag, " ZQ->done"}, doneRise - cmdCyc[7], ZW);
    end
    check(doneDrop == 0, "R10", {tag, " done held"}, doneDrop, 0);
    check(errRise < 0, "R11", {tag, " no error"}, errRise, -1);
    check(nopBad == 0, "R12", {tag, " NOP lines idle"}, nopBad, 0);
  endtask

  // BL8, lowest codes, default terminations
  task automatic testDefault();
    setCfg(1'b0, 9, 10, 9, 4, 1'b0, 3, 1);
    runSeq();
    checkNormal("default", 'h0100, 'h0300, 'h0200, 'h0000);
  endtask

  // BL4, out-of-order codes CL17 / WR22, 48 ohm drive
  task automatic testChopMid();
    setCfg(1'b1, 17, 22, 16, 8, 1'b1, 7, 4);
    runSeq();
    checkNormal("chop", 'h0F66, 'h0702, 'h0828, 'h1000);
  endtask

  // top codes CL32 / WR28 reach MR0 bits 12 and 13
  task automatic testTopCodes();
    setCfg(1'b0, 32, 28, 20, 6, 1'b0, 0, 0);
    runSeq();
    checkNormal("top", 'h3334, 'h0000, 'h0038, 'h0800);
  endtask

  task automatic testBadCfg(input string tag, input int cl, input int wr,
                            input int cwl, input int ccd);
    setCfg(1'b0, cl, wr, cwl, ccd, 1'b0, 3, 1);
    runSeq();
    check(nCmd == 0, "R11", {tag, " no commands"}, nCmd, 0);
    check(errRise >= 0 && errRise - ckeRise == CW, "R11", {tag, " error cycle"},
          errRise - ckeRise, CW);
    check(doneRise < 0, "R11", {tag, " done stays low"}, doneRise, -1);
    check(nopBad == 0, "R12", {tag, " NOP lines idle"}, nopBad, 0);
  endtask

  task automatic testMidReset();
    setCfg(1'b0, 9, 10, 9, 4, 1'b0, 3, 1);
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    repeat (RW + CW + 3) @(negedge clk);
    check(memCke == 1'b1, "R3", "mid-reset setup cke high", int'(memCke), 1);
    rstN = 1'b0;
    @(negedge clk);
    checkResetState("mid-sequence");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    checkResetState("power-on");
    testDefault();
    testChopMid();
    testTopCodes();
    testBadCfg("bad CL", 8, 10, 9, 4);
    testBadCfg("bad WR", 9, 11, 9, 4);
    testBadCfg("bad CWL", 9, 10, 13, 4);
    testBadCfg("bad tCCD", 9, 10, 9, 9);
    testMidReset();
    testDefault();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule